// File: doc/BRIEF.md
# Two-Stage Prescaled Down-Counter Timer

This block is a register-programmed timer with two cascaded stages. A prescaler counts down on every clock cycle from a programmable start value. Each time it passes zero it produces one scaled tick and restarts. Each scaled tick decrements a wide main counter. When the main counter is at zero and a tick arrives, the timer underflows: a sticky interrupt flag is set and the output pin changes level.

Software programs both start values and a control word through a small synchronous write bus. It reads the live counter, the prescaler and the flag back through a combinational read port. Three control bits decide what happens at underflow. With the reload bit set the counter restarts from its start value, which gives a periodic timer. With only the stop bit set the counter stays at zero and the timer disables itself, which gives a one-shot. With neither set the counter wraps to all ones and keeps counting. A hold bit freezes both stages. A load bit forces both start values into the live stages.

Top module: `scaled_downcounter_timer`

Register map (word address on `bus_addr`):
- 0: write sets the counter start value; read returns the live counter.
- 1: write sets the prescaler start value (low 8 bits); read returns the live prescaler.
- 2: control. Bit 0 enable, bit 1 reload, bit 2 load, bit 3 hold, bit 4 stop.
- 3: status. Bit 0 is the interrupt flag; writing 1 to bit 0 clears it.

## Requirements
- R1: After reset, all registers read 0 at addresses 0 to 3, and `irq` and `tout` are 0.
- R2: With a prescaler start value of 0 and the timer running, the counter read at address 0 decreases by one on every clock cycle.
- R3: With a prescaler start value of P, the counter decreases exactly once in every P+1 consecutive cycles.
- R4: With control bit 1 (reload) set, an underflow reloads the counter start value, so the underflow period is (C+1)*(P+1) cycles.
- R5: With bit 4 (stop) set and bit 1 clear, an underflow leaves the counter at 0 and clears bit 0 (enable). A control write in that same cycle takes priority.
- R6: With bits 1 and 4 both clear, an underflow wraps the counter to all ones and counting continues.
- R7: Every underflow toggles `tout` and sets the flag that drives `irq`.
- R8: The flag stays set until a write of 1 to address 3 bit 0 clears it.
- R9: When an underflow and a flag-clear write fall in the same cycle, the flag ends up set.
- R10: While bit 3 (hold) is set, the counter and the prescaler keep their values, and no underflow, toggle or flag occurs.
- R11: Writing bit 2 (load) copies both start values into the live stages on the next cycle, ahead of any counting. The bit then reads back as 0.
- R12: Address 0 returns the live counter value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Sticky underflow interrupt flag |
| tout | output | 1 | Output level, toggled at each underflow |

## Verification
Two events can land in the same cycle. Software may write the flag-clear bit in the very cycle in which an underflow sets the flag. Software may also write the control word in the cycle in which a one-shot underflow clears the enable bit. The bench provokes the first case with both start values at 0, so that every cycle underflows. It then expects `irq` to remain high after the clear write. A behavioural reference model runs alongside the design and applies the same priority rules: set beats clear, and a software write beats the self-disable. Every clock, the model's `irq`, `tout` and read data are compared against the design.

// File: rtl/scaled_downcounter_timer.sv
`timescale 1ns/1ps
module scaled_downcounter_timer #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tout
);
  localparam logic [CNT_W-1:0] CNT_ALL1 = '1;

  logic [PSC_W-1:0] psc_pre, psc;
  logic [CNT_W-1:0] cnt_pre, cnt;
  logic en, rld, hold, saz, load_pend, flag, tout_q;

  wire wr_cpre = bus_we && bus_addr == 2'd0;
  wire wr_ppre = bus_we && bus_addr == 2'd1;
  wire wr_ctl  = bus_we && bus_addr == 2'd2;
  wire wr_clr  = bus_we && bus_addr == 2'd3 && bus_wdata[0];
  wire run     = en && !hold && !load_pend;
  wire tick    = run && psc == '0;
  wire uf      = tick && cnt == '0;

  assign irq  = flag;
  assign tout = tout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_pre <= '0; cnt_pre <= '0; psc <= '0; cnt <= '0;
      en <= 1'b0; rld <= 1'b0; hold <= 1'b0; saz <= 1'b0;
      load_pend <= 1'b0; flag <= 1'b0; tout_q <= 1'b0;
    end else begin
      if (wr_cpre) cnt_pre <= bus_wdata[CNT_W-1:0];
      if (wr_ppre) psc_pre <= bus_wdata[PSC_W-1:0];
      if (uf && saz && !rld) en <= 1'b0;
      if (wr_ctl) begin
        en   <= bus_wdata[0];
        rld  <= bus_wdata[1];
        hold <= bus_wdata[3];
        saz  <= bus_wdata[4];
      end
      load_pend <= wr_ctl && bus_wdata[2];

      if (load_pend) begin
        psc <= psc_pre;
        cnt <= cnt_pre;
      end else if (tick) begin
        psc <= psc_pre;
        if (cnt != '0)  cnt <= cnt - 1'b1;
        else if (rld)   cnt <= cnt_pre;
        else if (saz)   cnt <= '0;
        else            cnt <= CNT_ALL1;
      end else if (run) begin
        psc <= psc - 1'b1;
      end

      if (uf)          flag <= 1'b1;
      else if (wr_clr) flag <= 1'b0;
      if (uf) tout_q <= !tout_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[CNT_W-1:0] = cnt;
      2'd1: bus_rdata[PSC_W-1:0] = psc;
      2'd2: bus_rdata[4:0] = {saz, hold, load_pend, rld, en};
      default: bus_rdata[0] = flag;
    endcase
  end
endmodule

// File: rtl/scaled_downcounter_timer_checker.sv
`timescale 1ns/1ps
module scaled_downcounter_timer_checker #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [PSC_W-1:0] psc,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_pre,
  input logic             en,
  input logic             rld,
  input logic             hold,
  input logic             saz,
  input logic             load_pend,
  input logic             irq,
  input logic             tout
);
  wire ctl_wr = bus_we && bus_addr == 2'd2;
  wire clr_wr = bus_we && bus_addr == 2'd3 && bus_wdata[0];

  a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load_pend) |=> ($stable(cnt) && $stable(psc)));

  a_r5_oneshot_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold && !load_pend && psc == '0 && cnt == '0 && saz && !rld && !ctl_wr)
      |=> (cnt == '0 && !en));

  a_r7_toggle_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tout != $past(tout)) |-> irq);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  a_r11_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pend && !bus_we) |=> (!load_pend && cnt == $past(cnt_pre)));
endmodule

bind scaled_downcounter_timer scaled_downcounter_timer_checker #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .psc(psc), .cnt(cnt), .cnt_pre(cnt_pre), .en(en), .rld(rld), .hold(hold), .saz(saz),
  .load_pend(load_pend), .irq(irq), .tout(tout)
);

// File: tb/scaled_downcounter_timer_bench.sv
`timescale 1ns/1ps
module scaled_downcounter_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, tout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scaled_downcounter_timer u_scaled_downcounter_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tout(tout)
  );

  // behavioural reference model
  longint m_cnt = 0, m_cpre = 0;
  int m_psc = 0, m_ppre = 0;
  bit m_en = 0, m_rld = 0, m_hold = 0, m_saz = 0, m_ld = 0, m_flag = 0, m_tout = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cpre = 0; m_psc = 0; m_ppre = 0;
      m_en = 0; m_rld = 0; m_hold = 0; m_saz = 0; m_ld = 0; m_flag = 0; m_tout = 0;
    end else begin
      bit under;
      bit stop_now;
      under = 0;
      stop_now = 0;
      if (m_ld) begin
        m_psc = m_ppre;
        m_cnt = m_cpre;
      end else if (m_en && !m_hold) begin
        if (m_psc == 0) begin
          m_psc = m_ppre;
          if (m_cnt == 0) begin
            under = 1;
            if (m_rld) m_cnt = m_cpre;
            else if (m_saz) begin m_cnt = 0; stop_now = 1; end
            else m_cnt = 64'hFFFF_FFFF;
          end else m_cnt = m_cnt - 1;
        end else m_psc = m_psc - 1;
      end
      if (stop_now) m_en = 0;
      m_ld = 0;
      if (under) begin m_flag = 1; m_tout = !m_tout; end
      if (bus_we) begin
        case (bus_addr)
          2'd0: m_cpre = bus_wdata;
          2'd1: m_ppre = bus_wdata & 255;
          2'd2: begin
            m_en = bus_wdata[0]; m_rld = bus_wdata[1]; m_ld = bus_wdata[2];
            m_hold = bus_wdata[3]; m_saz = bus_wdata[4];
          end
          default: if (bus_wdata[0] && !under) m_flag = 0;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_cnt);
      2'd1: return 32'(m_psc);
      2'd2: return {27'd0, m_saz, m_hold, m_ld, m_rld, m_en};
      default: return {31'd0, m_flag};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      check("R8 model irq", {31'd0, irq}, {31'd0, m_flag});
      check("R7 model tout", {31'd0, tout}, {31'd0, m_tout});
      check("R12 model rdata", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    int toggles;
    logic last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), a);
      check("R1 reset read", a, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset tout", {31'd0, tout}, 32'd0);

    // R2/R4: prescaler 0, counter 3, periodic
    wr(1, 0); wr(0, 3); wr(2, 32'h07);
    idle(2);
    rd(2, a);
    check("R11 load bit self-clears", a & 32'h4, 32'd0);
    rd(0, a); rd(0, b);
    check("R2 decrement per cycle", b, (a == 0) ? 32'd3 : a - 1);
    toggles = 0; last = tout;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tout !== last) toggles++;
      last = tout;
    end
    check("R4 R7 ten underflows in 40 cycles", 32'(toggles), 32'd10);

    // R3: prescaler 2, counter 4
    wr(1, 2); wr(0, 4); wr(2, 32'h07);
    idle(4);
    rd(0, a); idle(2); rd(0, b);
    check("R3 one decrement per 3 cycles", b, (a == 0) ? 32'd4 : a - 1);

    // R9: underflow every cycle, clear in the same cycle
    wr(1, 0); wr(0, 0); wr(2, 32'h07);
    idle(3);
    wr(3, 1);
    check("R9 set wins over clear", {31'd0, irq}, 32'd1);

    // R10 hold
    wr(2, 32'h0B);
    wr(3, 1);
    rd(0, a); last = tout; idle(10); rd(0, b);
    check("R10 counter frozen", b, a);
    check("R10 no flag while held", {31'd0, irq}, 32'd0);
    check("R10 no toggle while held", {31'd0, tout}, {31'd0, last});

    // R8 clear when idle
    wr(2, 32'h00);
    wr(3, 1);
    idle(10);
    check("R8 flag stays clear", {31'd0, irq}, 32'd0);

    // R5 one-shot
    wr(1, 1); wr(0, 5); wr(2, 32'h15);
    idle(30);
    rd(0, a);
    check("R5 counter stays at zero", a, 32'd0);
    rd(2, a);
    check("R5 enable cleared", a, 32'h10);
    check("R5 R7 flag set", {31'd0, irq}, 32'd1);

    // R6 wrap
    wr(3, 1); wr(1, 200); wr(0, 0); wr(2, 32'h05);
    idle(250);
    rd(0, a);
    check("R6 wrap to all ones", a, 32'hFFFF_FFFF);
    rd(2, a);
    check("R6 still enabled", a & 32'h1, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule